// File: doc/BRIEF.md
# Edge-Aligned Bit Clock Recovery

This block produces a one-clock strobe at the bit rate of an asynchronous serial line. The local clock must run at 2N times the symbol rate, and N is a compile-time parameter. The serial input first passes through a two-flop synchronizer. A transition in either direction then yields an edge pulse. Each edge pulse restarts a counter with a modulus that depends on the current mode, so that the next strobe falls close to the middle of the bit. After that, the counter runs freely at the full bit period. A line that holds one level for a long time, or that goes silent, therefore still gets one strobe per bit period. The phase is corrected again at the next transition.

The mode controller has two states. TRACK is the free-running state, with modulus 2N and terminal count 2N-1. ALIGN is the short mid-bit state, with terminal count N-2. It has four transitions:
- RESET_TO_TRACK: synchronous reset.
- TRACK_TO_ALIGN: an edge pulse in TRACK.
- ALIGN_RESTART: an edge pulse in ALIGN; the state stays ALIGN and the count restarts.
- ALIGN_TO_TRACK: the short terminal count is reached with no edge pulse.

Sampling the data with the strobe, framing and word assembly are left to the logic downstream.

Top module: `bit_clock_recover`

## Requirements
- R1: While `rst` is high at a rising clock edge, `bit_strobe` is 0 at that edge, the count returns to 0 and the mode becomes TRACK. With `serial_in` held constant after reset, the first strobe appears 2N clock edges after the last reset edge.
- R2: Rising and falling transitions of `serial_in` are treated the same. The new level is captured at the first clock edge after the change. The restart of the count takes effect two edges after that capture.
- R3: A restart sets the count to 0 and the mode to ALIGN. If no further edge arrives, the strobe rises N-1 edges after the restart, which is N+1 edges after the edge that first captured the new level.
- R4: The short-count strobe moves the mode to TRACK. From then on, strobes repeat every 2N clock edges, and the count never exceeds 2N-1.
- R5: Without transitions, strobes continue at the 2N period indefinitely.
- R6: A transition during ALIGN restarts the short count from 0. The mode remains ALIGN.
- R7: If a restart falls on the same edge as a terminal count, in either mode, the restart wins and no strobe is produced on that edge.
- R8: `bit_strobe` is registered and is never high for two edges in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock at 2N times the symbol rate |
| rst | input | 1 | Synchronous reset, active high |
| serial_in | input | 1 | Asynchronous serial data |
| bit_strobe | output | 1 | One-clock strobe per recovered bit |

## Verification
The bench builds the block with N = 3. This is the smallest legal value: the alignment count is a single step and the bit period is six clocks. At this size, a restart placed exactly on a short-count terminal or on a free-running terminal can be reached by a toggle only N-1 cycles after the previous one. Back-to-back transitions in every cycle are also reachable, as are thousands of bit periods within a short run. Every cycle's strobe is compared against the timing rule in R1 to R7.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    typedef enum logic {
        MODE_TRACK = 1'b0,
        MODE_ALIGN = 1'b1
    } bcr_mode_e;

endpackage

// File: rtl/bcr_edge_detect.sv
module bcr_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // synchronizer chain, stage 0 samples the asynchronous line
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], din};
            prev_q <= sync_q[LAST];
        end
    end

    // either direction of change flags an edge
    always_comb edge_pulse = sync_q[LAST] ^ prev_q;

    // R2: a pulse means the level leaving the chain moved one cycle earlier
    assert_edge_both_ways_R2: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |-> ($past(sync_q[LAST-1]) != $past(sync_q[LAST])));

endmodule

// File: rtl/bcr_mode_fsm.sv
module bcr_mode_fsm
    import bcr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      edge_pulse,
    input  logic      term_hit,
    output bcr_mode_e mode
);
    bcr_mode_e mode_q, mode_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_TRACK;      // RESET_TO_TRACK
        else     mode_q <= mode_d;
    end

    // transition logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_TRACK: begin
                if (edge_pulse) mode_d = MODE_ALIGN;      // TRACK_TO_ALIGN
            end
            MODE_ALIGN: begin
                if (edge_pulse)    mode_d = MODE_ALIGN;   // ALIGN_RESTART
                else if (term_hit) mode_d = MODE_TRACK;   // ALIGN_TO_TRACK
            end
            default: mode_d = MODE_TRACK;
        endcase
    end

    always_comb mode = mode_q;

    assert_edge_enters_align_R3: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> (mode == MODE_ALIGN));

    assert_align_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ALIGN && term_hit && !edge_pulse) |=> (mode == MODE_TRACK));

    assert_track_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TRACK && !edge_pulse) |=> (mode == MODE_TRACK));

endmodule

// File: rtl/bcr_counter.sv
module bcr_counter
    import bcr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      edge_pulse,
    input  bcr_mode_e mode,
    output logic      term_hit,
    output logic      strobe
);
    localparam int              CW         = $clog2(2 * N);
    localparam logic [CW-1:0]   ALIGN_LAST = CW'(N - 2);
    localparam logic [CW-1:0]   TRACK_LAST = CW'(2 * N - 1);

    logic [CW-1:0] cnt_q;

    // terminal count depends on the mode
    always_comb begin
        term_hit = 1'b0;
        unique case (mode)
            MODE_ALIGN: term_hit = (cnt_q == ALIGN_LAST);
            MODE_TRACK: term_hit = (cnt_q == TRACK_LAST);
            default:    term_hit = 1'b0;
        endcase
    end

    // count register
    always_ff @(posedge clk) begin
        if (rst || edge_pulse) cnt_q <= '0;
        else if (term_hit)     cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    // strobe register; a restart suppresses the strobe
    always_ff @(posedge clk) begin
        if (rst) strobe <= 1'b0;
        else     strobe <= term_hit && !edge_pulse;
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TRACK_LAST);

    assert_edge_clears_R3: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> (cnt_q == '0));

    assert_edge_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (edge_pulse && term_hit) |=> !strobe);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    assert_align_counts_up_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ALIGN && !edge_pulse && !term_hit) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/bit_clock_recover.sv
module bit_clock_recover
    import bcr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic serial_in,
    output logic bit_strobe
);
    logic      edge_pulse;
    logic      term_hit;
    bcr_mode_e mode;

    bcr_edge_detect #(
        .SYNC_STAGES(2)
    ) u_edge (
        .clk        (clk),
        .rst        (rst),
        .din        (serial_in),
        .edge_pulse (edge_pulse)
    );

    bcr_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .edge_pulse (edge_pulse),
        .term_hit   (term_hit),
        .mode       (mode)
    );

    bcr_counter #(
        .N(N)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .edge_pulse (edge_pulse),
        .mode       (mode),
        .term_hit   (term_hit),
        .strobe     (bit_strobe)
    );

    // R1: a reset edge always leaves the strobe low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !bit_strobe);

endmodule

// File: tb/tb_bit_clock_recover.sv
`timescale 1ns/1ps
module tb_bit_clock_recover;
    localparam int N = 3;
    localparam int P = 2 * N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic serial_in = 1'b0;
    logic bit_strobe;

    int   pcnt = 0;
    int   total = 0;
    int   bad = 0;
    int   lc = 0;
    int   last_n = 0;
    logic [3:0] hist = 4'b0;
    logic cur = 1'b0;
    bit   done = 1'b0;

    bit_clock_recover #(.N(N)) dut (
        .clk        (clk),
        .rst        (rst),
        .serial_in  (serial_in),
        .bit_strobe (bit_strobe)
    );

    always #2 clk = ~clk;
    always @(posedge clk) pcnt <= pcnt + 1;

    // expected strobe at rising edge n, given the latest restart index
    function automatic bit exp_strobe(input int n, input int last, input bit in_rst);
        int d;
        if (in_rst) return 1'b0;
        d = n - last;
        if (d < N - 1) return 1'b0;
        return ((d - (N - 1)) % P) == 0;
    endfunction

    // check the edge just past, then drive the next inputs
    task automatic step(input logic nd, input logic nr, input string tag);
        int n;
        bit rst_here, clr_here, e;
        @(negedge clk);
        n = pcnt;
        rst_here = rst;
        clr_here = !rst && (hist[2] != hist[3]);   // R2: restart three edges after the drive
        if (rst_here)      lc = n + N + 1;         // R1: virtual restart, first strobe 2N later
        else if (clr_here) lc = n;
        e = exp_strobe(n, lc, rst_here);
        total++;
        if (bit_strobe !== e) begin
            bad++;
            $display("FAIL %s edge %0d bit_strobe actual=%b expected=%b", tag, n, bit_strobe, e);
        end
        serial_in = nd;
        rst = nr;
        hist = {hist[2:0], nd};
        last_n = n;
    endtask

    task automatic hold(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) step(cur, 1'b0, tag);
    endtask

    task automatic toggle(input string tag);
        cur = ~cur;
        step(cur, 1'b0, tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state and free-run afterwards
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R1");
        hold(5 * P, "R1");
        // R2/R3: rising transition, then R4 tracking
        toggle("R2");
        hold(N + 1, "R3");
        hold(3 * P, "R4");
        // R2: falling transition
        toggle("R2");
        hold(3 * P, "R4");
        // R5: long constant run
        hold(20 * P, "R5");
        // R6: second transition while aligning
        toggle("R6");
        toggle("R6");
        hold(3 * P, "R6");
        // R7: restart on a free-running terminal count
        hold(P, "R7");
        while (!exp_strobe(last_n + 1 + 3, lc, 1'b0)) step(cur, 1'b0, "R7");
        toggle("R7");
        hold(3 * P, "R7");
        // R7: restart on the short-count terminal
        toggle("R7");
        hold(N - 2, "R7");
        toggle("R7");
        hold(3 * P, "R7");
        // R8: toggling on every edge, strobe stays silent
        for (int i = 0; i < 12; i++) toggle("R8");
        hold(3 * P, "R8");
        // R1: reset in mid-run
        cur = 1'b0;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R1");
        hold(3 * P, "R1");
        // random run lengths
        for (int k = 0; k < 300; k++) begin
            toggle("R8");
            hold(int'($urandom % (3 * P)), "R4");
        end
        hold(2 * P, "R5");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule